// File: doc/BRIEF.md
# Clock Gate Controller with Hardware/Software Hand-over

This block gates one clock. A 32-bit control word at a fixed offset holds three fields: a switch that turns the clock on or off, a mode bit that chooses who drives the gate, and a read-only status flag. With the mode bit at 1 the switch drives the gate. With the mode bit at 0 an idle-request input drives it instead: while the request is high the clock stops. That input passes through a two-flop synchroniser before it can act.

The status flag shows whether the gate is actually open. It follows the gate enable two clock cycles late, which stands in for the synchroniser delay. Software writes the switch and then polls the flag to learn when the change is complete. Writes to the control word are locked. They are accepted only after a parameterised password has been written to the access word at offset 0. Writing any other value to offset 0 locks writes again. A build option removes the switch and the mode bit, which leaves a gate driven only by the idle request.

The gate is a latch-based cell. The enable is captured while the clock is low and ANDed with the clock.

Top module: `clk_gate_ctl`

## Requirements
- R1: After reset the mode bit reads 1, the switch reads 1, the status flag reads 1, writes are locked (offset 0 reads 0) and `gclk` toggles with `clk`.
- R2: A write to the control word while writes are locked leaves the switch and the mode bit unchanged. Writing `PASSWORD` to offset 0 unlocks writes, and offset 0 then reads 1 in bit 0.
- R3: Writing any value other than `PASSWORD` to offset 0 locks writes again. Later control-word writes are then ignored.
- R4: In software mode (mode bit, bit `SEL_BIT`, is 1) the switch (bit `EN_BIT`) decides the gate. If the switch is written 0 after edge k, no `gclk` pulse appears from edge k+1 on. If it is written 1, the pulses return from edge k+1.
- R5: In hardware mode (mode bit 0) the gate is open while the synchronised idle request is low. A change of `idle_req` sampled at edge j reaches `gclk` at edge j+2.
- R6: In software mode `idle_req` has no effect on `gclk` or on the status flag.
- R7: The status flag (bit `STAT_BIT` of the control word, also on the `gate_status` port) equals the gate enable from two cycles earlier. After a write at edge k changes the gate, the flag still shows the old state after edge k+1 and the new state after edge k+2.
- R8: The status flag is read-only. Data written into bit `STAT_BIT` has no effect.
- R9: With `HW_ONLY`=1 the switch and the mode bit read 0 and ignore writes. The gate follows only the synchronised idle request, and the status flag still reports it.
- R10: The control word (offset `GATE_OFF`) reads the switch at bit `EN_BIT`, the mode bit at bit `SEL_BIT` and the status flag at bit `STAT_BIT`, with all other bits 0. Offset 0 reads the unlock state in bit 0. Every other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | ADDR_W | Byte offset for both reads and writes |
| wdata | input | 32 | Write data |
| idle_req | input | 1 | Asynchronous idle request; stops the clock in hardware mode |
| rdata | output | 32 | Read data for `addr` (combinational) |
| gclk | output | 1 | Gated clock |
| gate_status | output | 1 | Status flag, two cycles behind the gate enable |

## Verification
The assertions check the following on every cycle:
- the lock and unlock effect of writes to offset 0;
- that locked writes leave the control fields unchanged;
- the two-cycle relation from `idle_req` to the gate in hardware mode;
- that the gate holds steady in software mode while the fields hold;
- the two-cycle status lag;
- the fixed-zero fields of the hardware-only build.

Only the bench's scenarios can show:
- the pulses on `gclk` itself;
- the exact read-back layout;
- that status bits written by software are dropped;
- the end-to-end hand-over between modes under random traffic.

// File: rtl/clkg_pkg.sv
package clkg_pkg;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic wr_ok;
        logic en;
        logic sel;
    } gate_regs_t;
endpackage

// File: rtl/clkg_sync.sv
module clkg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/clkg_gate_cell.sv
module clkg_gate_cell (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    // enable captured while clk is low, so gclk never glitches
    always_latch begin
        if (!clk) en_lat = en;
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/clkg_regs.sv
module clkg_regs
    import clkg_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int unsigned       GATE_OFF = 4,
    parameter logic [DATA_W-1:0] PASSWORD = 32'h00A5_A501,
    parameter int                EN_BIT   = 0,
    parameter int                SEL_BIT  = 1,
    parameter bit                HW_ONLY  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              sw_en,
    output logic              sw_sel,
    output logic              wr_ok
);
    localparam logic SW_RST = !HW_ONLY;
    localparam logic [ADDR_W-1:0] GATE_ADDR = ADDR_W'(GATE_OFF);

    gate_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (addr == '0) begin
                r_d.wr_ok = (wdata == PASSWORD);
            end else if (addr == GATE_ADDR && r_q.wr_ok && !HW_ONLY) begin
                r_d.en  = wdata[EN_BIT];
                r_d.sel = wdata[SEL_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{wr_ok: 1'b0, en: SW_RST, sel: SW_RST};
        else        r_q <= r_d;
    end

    assign sw_en  = r_q.en;
    assign sw_sel = r_q.sel;
    assign wr_ok  = r_q.wr_ok;
endmodule

// File: rtl/clk_gate_ctl.sv
module clk_gate_ctl
    import clkg_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int unsigned       GATE_OFF = 4,
    parameter logic [DATA_W-1:0] PASSWORD = 32'h00A5_A501,
    parameter int                EN_BIT   = 0,
    parameter int                SEL_BIT  = 1,
    parameter int                STAT_BIT = 8,
    parameter bit                HW_ONLY  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              idle_req,
    output logic [DATA_W-1:0] rdata,
    output logic              gclk,
    output logic              gate_status
);
    localparam logic [ADDR_W-1:0] GATE_ADDR = ADDR_W'(GATE_OFF);

    logic sw_en, sw_sel, wr_ok;
    logic idle_sync, gate_en, status;

    clkg_regs #(
        .ADDR_W(ADDR_W), .GATE_OFF(GATE_OFF), .PASSWORD(PASSWORD),
        .EN_BIT(EN_BIT), .SEL_BIT(SEL_BIT), .HW_ONLY(HW_ONLY)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .sw_en(sw_en), .sw_sel(sw_sel), .wr_ok(wr_ok)
    );

    clkg_sync #(.STAGES(2), .RST_VAL(1'b0)) u_idle_sync (
        .clk(clk), .rst_n(rst_n), .din(idle_req), .dout(idle_sync)
    );

    generate
        if (HW_ONLY) begin : g_auto
            always_comb gate_en = ~idle_sync;
        end else begin : g_mux
            always_comb gate_en = sw_sel ? sw_en : ~idle_sync;
        end
    endgenerate

    clkg_sync #(.STAGES(2), .RST_VAL(1'b1)) u_stat_sync (
        .clk(clk), .rst_n(rst_n), .din(gate_en), .dout(status)
    );

    clkg_gate_cell u_cell (.clk(clk), .en(gate_en), .gclk(gclk));

    always_comb begin
        rdata = '0;
        if (addr == '0) begin
            rdata[0] = wr_ok;
        end else if (addr == GATE_ADDR) begin
            rdata[EN_BIT]   = sw_en;
            rdata[SEL_BIT]  = sw_sel;
            rdata[STAT_BIT] = status;
        end
    end

    assign gate_status = status;
endmodule

// File: rtl/clk_gate_ctl_chk.sv
module clk_gate_ctl_chk
    import clkg_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int unsigned       GATE_OFF = 4,
    parameter logic [DATA_W-1:0] PASSWORD = 32'h00A5_A501,
    parameter bit                HW_ONLY  = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              idle_req,
    input logic              sw_en,
    input logic              sw_sel,
    input logic              wr_ok,
    input logic              gate_en,
    input logic              status
);
    logic [1:0] cyc_q;
    logic       armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end
    assign armed = (cyc_q == 2'd3);

    assert_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && wdata == PASSWORD) |=> wr_ok);

    assert_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && wdata != PASSWORD) |=> !wr_ok);

    assert_locked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(GATE_OFF) && !wr_ok) |=> ($stable(sw_en) && $stable(sw_sel)));

    assert_hw_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !sw_sel) |-> (gate_en == !$past(idle_req, 2)));

    assert_sw_ignores_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && sw_sel && $stable(sw_sel) && $stable(sw_en)) |-> $stable(gate_en));

    assert_status_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (status == $past(gate_en, 2)));

    generate
        if (HW_ONLY) begin : g_hw_chk
            assert_fields_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (!sw_en && !sw_sel));
        end
    endgenerate
endmodule

bind clk_gate_ctl clk_gate_ctl_chk #(
    .ADDR_W(ADDR_W), .GATE_OFF(GATE_OFF), .PASSWORD(PASSWORD), .HW_ONLY(HW_ONLY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .idle_req(idle_req), .sw_en(sw_en), .sw_sel(sw_sel), .wr_ok(wr_ok),
    .gate_en(gate_en), .status(status)
);

// File: tb/clk_gate_ctl_bench.sv
module clk_gate_ctl_bench;
    localparam int          ADDR_W = 8;
    localparam int          GOFF   = 4;
    localparam logic [31:0] PASS   = 32'h00A5_A501;
    localparam int          ENB    = 0;
    localparam int          SELB   = 1;
    localparam int          STB    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic idle_req = 1'b0;
    logic [31:0] rdata, rdata_h;
    logic gclk, gclk_h, gate_status, status_h;

    always #4 clk = ~clk;

    clk_gate_ctl #(.ADDR_W(ADDR_W), .GATE_OFF(GOFF), .PASSWORD(PASS),
        .EN_BIT(ENB), .SEL_BIT(SELB), .STAT_BIT(STB), .HW_ONLY(1'b0)) u_clk_gate_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .idle_req(idle_req), .rdata(rdata), .gclk(gclk), .gate_status(gate_status));

    clk_gate_ctl #(.ADDR_W(ADDR_W), .GATE_OFF(GOFF), .PASSWORD(PASS),
        .EN_BIT(ENB), .SEL_BIT(SELB), .STAT_BIT(STB), .HW_ONLY(1'b1)) u_clk_gate_ctl_hw (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .idle_req(idle_req), .rdata(rdata_h), .gclk(gclk_h), .gate_status(status_h));

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    logic m_ok, m_en, m_sel, m_s1, m_s2, m_st1, m_st2, h_st1, h_st2;

    function automatic logic m_gate();
        return m_sel ? m_en : ~m_s2;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [ADDR_W-1:0] a, input bit hw);
        logic [31:0] v;
        v = '0;
        if (a == '0) v[0] = m_ok;
        else if (a == ADDR_W'(GOFF)) begin
            if (!hw) begin
                v[ENB]  = m_en;
                v[SELB] = m_sel;
                v[STB]  = m_st2;
            end else begin
                v[STB]  = h_st2;
            end
        end
        return v;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic w, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                        input logic idle, input string tag);
        logic g_old, h_old;
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; idle_req = idle;
        g_old = m_gate();
        h_old = ~m_s2;
        @(posedge clk);
        if (w && a == '0) m_ok = (d == PASS);
        else if (w && a == ADDR_W'(GOFF) && m_ok) begin
            m_en  = d[ENB];
            m_sel = d[SELB];
        end
        m_st2 = m_st1; m_st1 = g_old;
        h_st2 = h_st1; h_st1 = h_old;
        m_s2 = m_s1;   m_s1 = idle;
        #2;
        chk({31'b0, gclk}, {31'b0, g_old}, {tag, " gclk"});
        chk({31'b0, gate_status}, {31'b0, m_st2}, {tag, " R7 status"});
        chk(rdata, exp_rd(a, 1'b0), {tag, " R10 rdata"});
        chk({31'b0, gclk_h}, {31'b0, h_old}, "R9 hw gclk");
        chk({31'b0, status_h}, {31'b0, h_st2}, "R9 hw status");
        chk(rdata_h, exp_rd(a, 1'b1), "R9 hw rdata");
    endtask

    function automatic logic [31:0] gword(input logic en, input logic sel, input logic st);
        logic [31:0] v;
        v = '0;
        v[ENB] = en; v[SELB] = sel; v[STB] = st;
        return v;
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        void'($urandom(32'd20240611));
        m_ok = 0; m_en = 1; m_sel = 1; m_s1 = 0; m_s2 = 0;
        m_st1 = 1; m_st2 = 1; h_st1 = 1; h_st2 = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        step(0, ADDR_W'(GOFF), 0, 0, "R1");
        chk(rdata, gword(1, 1, 1), "R1 reset word");
        step(0, 0, 0, 0, "R1");
        chk(rdata, 32'h0, "R1 locked after reset");

        // R2 locked write ignored
        step(1, ADDR_W'(GOFF), gword(0, 0, 0), 0, "R2");
        step(0, ADDR_W'(GOFF), 0, 0, "R2");
        chk(rdata, gword(1, 1, 1), "R2 locked write ignored");
        step(1, 0, PASS, 0, "R2");
        chk(rdata, 32'h1, "R2 unlocked");

        // R4 and R7: switch off then on, status lag
        step(1, ADDR_W'(GOFF), gword(0, 1, 0), 1, "R4");
        chk({31'b0, gate_status}, 32'h1, "R7 status still old after write edge");
        step(0, ADDR_W'(GOFF), 0, 1, "R7");
        chk({31'b0, gate_status}, 32'h1, "R7 status old one edge later");
        step(0, ADDR_W'(GOFF), 0, 1, "R7");
        chk({31'b0, gate_status}, 32'h0, "R7 status new two edges later");
        chk({31'b0, gclk}, 32'h0, "R4 clock stopped");
        // R6 idle toggles ignored in software mode
        step(0, ADDR_W'(GOFF), 0, 0, "R6");
        step(0, ADDR_W'(GOFF), 0, 1, "R6");
        step(0, ADDR_W'(GOFF), 0, 0, "R6");
        chk({31'b0, gclk}, 32'h0, "R6 idle ignored");

        // R8 status bit write ignored
        step(1, ADDR_W'(GOFF), gword(1, 1, 0), 0, "R8");
        repeat (3) step(0, ADDR_W'(GOFF), 0, 0, "R8");
        chk(rdata, gword(1, 1, 1), "R8 status read-only");
        step(1, ADDR_W'(GOFF), gword(1, 1, 1), 1, "R6");
        repeat (3) step(0, ADDR_W'(GOFF), 0, 1, "R6");
        chk({31'b0, gclk}, 32'h1, "R6 running despite idle");

        // R5 hardware mode
        step(1, ADDR_W'(GOFF), gword(1, 0, 0), 1, "R5");
        repeat (3) step(0, ADDR_W'(GOFF), 0, 1, "R5");
        chk({31'b0, gclk}, 32'h0, "R5 idle stops clock");
        step(0, ADDR_W'(GOFF), 0, 0, "R5");
        step(0, ADDR_W'(GOFF), 0, 0, "R5");
        chk({31'b0, gclk}, 32'h0, "R5 still stopped one edge after");
        step(0, ADDR_W'(GOFF), 0, 0, "R5");
        chk({31'b0, gclk}, 32'h1, "R5 running two edges after");

        // R3 relock
        step(1, 0, PASS ^ 32'h10, 0, "R3");
        chk(rdata, 32'h0, "R3 relocked");
        step(1, ADDR_W'(GOFF), gword(0, 1, 0), 0, "R3");
        step(0, ADDR_W'(GOFF), 0, 0, "R3");
        chk(rdata & gword(1, 1, 0), gword(1, 0, 0), "R3 write after relock ignored");
        step(0, 8'h0C, 0, 0, "R10");
        chk(rdata, 32'h0, "R10 unmapped offset");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [ADDR_W-1:0] a;
            logic idl;
            op = int'($urandom % 8);
            idl = (($urandom % 4) == 0) ? ~idle_req : idle_req;
            case ($urandom % 3)
                0: a = '0;
                1: a = ADDR_W'(GOFF);
                default: a = 8'h10;
            endcase
            rv = $urandom;
            if (rv == PASS) rv = ~rv;
            case (op)
                0: step(1, 0, PASS, idl, "R2 R4 R5 rnd");
                1: step(1, 0, rv, idl, "R3 rnd");
                2, 3: step(1, ADDR_W'(GOFF), rv, idl, "R4 R5 R8 rnd");
                default: step(0, a, 0, idl, "R6 R10 rnd");
            endcase
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule